// File: doc/BRIEF.md
# Split six-input lookup table

A configurable logic element that evaluates any Boolean function of six selector inputs. It holds 64 truth-table bits and is built as two independent five-input tables sharing the five low selectors. Each table is an explicit five-level tree of two-to-one multiplexers, one level per selector, and the stored bits sit at its leaves. The top selector drives a last two-to-one multiplexer that chooses between the two table results and produces the full-function output. A second output always carries the lower table. That lower table is the one the last multiplexer passes when the top selector is 0. The element can therefore act as one six-input function or as two five-input functions that share their inputs.

The truth table is written through a one-bit serial chain. The chain is made of two-bit storage cells and is advanced by a clock while a shift enable is high. Once the chain is loaded and the enable is low, both outputs are purely combinational functions of the selectors.

Top module: `split_lut6`

## Requirements
- R1: An active-low asynchronous reset clears all 64 stored bits, so both outputs are 0 for every selector value.
- R2: On each rising clock edge with the shift enable high, every stored bit moves up one index and the serial input enters at index 0. After 64 such edges, the first bit shifted in sits at index 63, so a pattern is loaded most significant bit first.
- R3: With the shift enable low, clock edges leave the stored contents unchanged whatever the serial input does.
- R4: The full output equals stored bit number sel_i[5:0], read as an unsigned index with sel_i[0] as the least significant bit.
- R5: The half output equals stored bit number {0, sel_i[4:0]} and does not depend on sel_i[5].
- R6: Indices 0 to 31 form the table used when sel_i[5] is 0, and indices 32 to 63 form the table used when sel_i[5] is 1.
- R7: With the configuration held, a change on the selectors reaches both outputs without any clock edge.
- R8: Shifting fewer than 64 bits moves the existing contents up by the number of bits shifted. Bits pushed past index 63 are lost, and the new bits fill the lowest indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration chain |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the configuration |
| cfg_shift_en_i | input | 1 | Advances the configuration chain by one bit per edge |
| cfg_bit_i | input | 1 | Serial configuration data |
| sel_i | input | 6 | Function inputs; sel_i[5] picks the table half |
| out_full_o | output | 1 | Six-input function result |
| out_half_o | output | 1 | Lower five-input table result |

## Verification
A corrupted storage cell appears only when the selectors address that cell. Each loaded pattern is therefore swept over all 64 selector values, and a stuck or misordered bit shows up on the same sweep, with no clock edge needed. A wrong select wiring inside a tree level swaps pairs or blocks of leaves, and the patterns with a single bit set expose it at once. A fault in the shift order shows up as a misplaced bit right after the next load or partial shift.

// File: rtl/split_lut_pkg.sv
package split_lut_pkg;
  localparam int unsigned LUT_IN_DEF = 6;

  // start index of tree level lvl in a flattened node vector for n leaves
  function automatic int unsigned tree_off(input int unsigned n, input int unsigned lvl);
    return 2 * n - ((2 * n) >> lvl);
  endfunction
endpackage

// File: rtl/cfg_pair_cell.sv
module cfg_pair_cell (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       shift_i,
  input  logic       bit_i,
  output logic [1:0] pair_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pair_o <= '0;
    else if (shift_i) pair_o <= {pair_o[0], bit_i};
  end
endmodule

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int unsigned CFG_BITS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic                bit_i,
  output logic [CFG_BITS-1:0] cfg_o
);
  localparam int unsigned CELLS = CFG_BITS / 2;

  logic [CELLS-1:0] cell_in;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    if (c == 0) begin : g_head
      assign cell_in[c] = bit_i;
    end else begin : g_link
      assign cell_in[c] = cfg_o[2*c-1];
    end
    cfg_pair_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(shift_i),
      .bit_i  (cell_in[c]),
      .pair_o (cfg_o[2*c+1:2*c])
    );
  end

  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && rst_ni) |=> $stable(cfg_o));

  a_r2_shift_one_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && rst_ni) |=> (cfg_o[0] == $past(bit_i)) &&
                            (cfg_o[CFG_BITS-1:1] == $past(cfg_o[CFG_BITS-2:0])));
endmodule

// File: rtl/lut_mux_tree.sv
module lut_mux_tree
  import split_lut_pkg::*;
#(
  parameter int unsigned SEL_W = 5
) (
  input  logic [(1<<SEL_W)-1:0] data_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic                  out_o
);
  localparam int unsigned LEAVES = 1 << SEL_W;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [NODES-1:0] node;

  assign node[LEAVES-1:0] = data_i;

  // level k is steered by sel_i[k]; level 0 sits next to the stored bits
  for (genvar k = 0; k < SEL_W; k++) begin : g_lvl
    localparam int unsigned IN_OFF  = tree_off(LEAVES, k);
    localparam int unsigned OUT_OFF = tree_off(LEAVES, k + 1);
    localparam int unsigned WIDTH   = LEAVES >> (k + 1);
    for (genvar j = 0; j < WIDTH; j++) begin : g_mux
      assign node[OUT_OFF+j] = sel_i[k] ? node[IN_OFF+2*j+1] : node[IN_OFF+2*j];
    end
  end

  assign out_o = node[NODES-1];
endmodule

// File: rtl/split_lut6.sv
module split_lut6
  import split_lut_pkg::*;
#(
  parameter int unsigned LUT_IN = LUT_IN_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_shift_en_i,
  input  logic              cfg_bit_i,
  input  logic [LUT_IN-1:0] sel_i,
  output logic              out_full_o,
  output logic              out_half_o
);
  localparam int unsigned HALF_IN   = LUT_IN - 1;
  localparam int unsigned CFG_BITS  = 1 << LUT_IN;
  localparam int unsigned HALF_BITS = CFG_BITS / 2;

  logic [CFG_BITS-1:0] cfg_q;
  logic                lo_out, hi_out;

  cfg_chain #(.CFG_BITS(CFG_BITS)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(cfg_shift_en_i),
    .bit_i  (cfg_bit_i),
    .cfg_o  (cfg_q)
  );

  lut_mux_tree #(.SEL_W(HALF_IN)) u_lo (
    .data_i(cfg_q[HALF_BITS-1:0]),
    .sel_i (sel_i[HALF_IN-1:0]),
    .out_o (lo_out)
  );

  lut_mux_tree #(.SEL_W(HALF_IN)) u_hi (
    .data_i(cfg_q[CFG_BITS-1:HALF_BITS]),
    .sel_i (sel_i[HALF_IN-1:0]),
    .out_o (hi_out)
  );

  assign out_full_o = sel_i[LUT_IN-1] ? hi_out : lo_out;
  assign out_half_o = lo_out;

  a_r4_full_reads_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_full_o == cfg_q[sel_i]);

  a_r5_half_reads_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_half_o == cfg_q[{1'b0, sel_i[HALF_IN-1:0]}]);

  a_r6_lower_half_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i[LUT_IN-1] |-> (out_full_o == out_half_o));
endmodule

// File: tb/tb_split_lut6.sv
module tb_split_lut6;
  typedef struct {
    logic  exp_full;
    logic  exp_half;
    string tag;
  } item_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_shift_en_i = 1'b0;
  logic       cfg_bit_i = 1'b0;
  logic [5:0] sel_i = '0;
  logic       out_full_o, out_half_o;

  logic [63:0] model;
  item_t       sb_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  event        sample_ev;

  always #2 clk_i = ~clk_i;

  split_lut6 dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_shift_en_i(cfg_shift_en_i),
    .cfg_bit_i     (cfg_bit_i),
    .sel_i         (sel_i),
    .out_full_o    (out_full_o),
    .out_half_o    (out_half_o)
  );

  // monitor: pop expected item and compare against the ports
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp += 2;
        if (out_full_o !== it.exp_full) begin
          n_bad++;
          $display("FAIL %s full sel=%0d actual=%b expected=%b", it.tag, sel_i, out_full_o, it.exp_full);
        end
        if (out_half_o !== it.exp_half) begin
          n_bad++;
          $display("FAIL %s half sel=%0d actual=%b expected=%b", it.tag, sel_i, out_half_o, it.exp_half);
        end
      end
    end
  end

  task automatic shift_bit(input logic b);
    @(negedge clk_i);
    cfg_shift_en_i = 1'b1;
    cfg_bit_i      = b;
    @(posedge clk_i);
    model = {model[62:0], b};
    @(negedge clk_i);
    cfg_shift_en_i = 1'b0;
  endtask

  // R2: most significant bit first
  task automatic load(input logic [63:0] pat);
    for (int i = 63; i >= 0; i--) shift_bit(pat[i]);
  endtask

  // R4 R5 R6 R7: selector changes without clock edges
  task automatic sweep(input string tag);
    for (int s = 0; s < 64; s++) begin
      item_t it;
      sel_i = s[5:0];
      #0.5;
      it.exp_full = model[s];
      it.exp_half = model[{1'b0, s[4:0]}];
      it.tag      = tag;
      sb_q.push_back(it);
      -> sample_ev;
      #0.5;
    end
  endtask

  initial begin
    model = '0;
    #1;
    sweep("R1 async reset");
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    sweep("R1 after release");

    load(64'h8000_0000_0000_0000);
    sweep("R2 first bit lands at 63");
    load(64'h0000_0000_0000_0001);
    sweep("R4 bit 0 only");
    load(64'h0000_0000_8000_0000);
    sweep("R6 top of lower table");
    load(64'h0000_0001_0000_0000);
    sweep("R6 bottom of upper table");
    load(64'hFFFF_FFFF_FFFF_FFFF);
    sweep("R4 all ones");
    load(64'hAAAA_5555_CCCC_3333);
    sweep("R5 mixed halves");
    load({$urandom, $urandom});
    sweep("R4 random a");
    load({$urandom, $urandom});
    sweep("R7 random b");

    // R3: clock with enable low and toggling data
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      cfg_bit_i = i[0];
    end
    sweep("R3 hold with enable low");

    // R8: partial shift of 8 bits
    for (int i = 0; i < 8; i++) shift_bit(i[1]);
    sweep("R8 partial shift");

    load({$urandom, $urandom});
    sweep("R5 random c");

    done = 1'b1;
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule